// File: doc/BRIEF.md
# Banked Stack Pointer Control Registers

This block is a small processor control register bank that sits beside a 16-entry, 32-bit general register file. General register 15 is always the live stack pointer. A stack mode flag in the status word selects which of two stack pointers register 15 currently holds: the interrupt stack pointer (mode 0) or the user stack pointer (mode 1). The pointer that is not live waits in a shadow register.

When a status write flips the stack mode, the block moves register 15 into the shadow of the pointer being left and loads register 15 from the shadow of the pointer being entered. Both moves happen on the same clock edge as the write. The two stack pointer control addresses are mode-aware: each reaches register 15 when its pointer is live and the shadow otherwise. The block also carries the general register file's own read and write ports, three plain 32-bit scratch registers, and a single-bit condition alias.

Control and general register reads are combinational from current state. Writes take effect at the next rising clock edge.

Top module: `sp_bank_ctrl`

## Requirements
- R1: Control address 0 reads the status word with backup stack mode at bit 15, backup interrupt enable at bit 14, backup condition at bit 8, stack mode at bit 7, interrupt enable at bit 6 and condition at bit 0. Every other bit reads 0. A write to address 0 loads all six flags from those same bit positions.
- R2: Control address 1 reads the condition flag in bit 0, with bits 31..1 at zero. A write to address 1 sets the condition from write-data bit 0 only and leaves the other five flags unchanged.
- R3: Control address 2 (interrupt stack pointer) reads and writes general register 15 when stack mode is 0, and its shadow register when stack mode is 1.
- R4: Control address 3 (user stack pointer) reads and writes general register 15 when stack mode is 1, and its shadow register when stack mode is 0.
- R5: A status write that changes stack mode from 0 to 1 stores the old register 15 as the interrupt stack pointer and loads register 15 with the user stack pointer, in the same edge. A read in the next cycle sees the new mapping.
- R6: A status write that changes stack mode from 1 to 0 stores the old register 15 as the user stack pointer and loads register 15 with the interrupt stack pointer, in the same edge.
- R7: A status write that leaves stack mode unchanged moves no register and updates only the six flags.
- R8: Control addresses 4, 5 and 6 are independent 32-bit storage registers. Control address 7 always reads zero and ignores writes.
- R9: While reset is low at a clock edge, all flags, shadows, storage registers and general registers become zero, so stack mode is 0.
- R10: The general register port reads any of the 16 registers combinationally. A write becomes visible from the next cycle.
- R11: If a general write to register 15 and a stack-mode-changing status write occur in the same cycle, the swap wins: the general write is dropped, and the value that moves into the shadow is the old register 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cr_raddr | input | 3 | Control register read address |
| cr_rdata | output | 32 | Control register read data (combinational) |
| cr_we | input | 1 | Control register write enable |
| cr_waddr | input | 3 | Control register write address |
| cr_wdata | input | 32 | Control register write data |
| gr_raddr | input | 4 | General register read address |
| gr_rdata | output | 32 | General register read data (combinational) |
| gr_we | input | 1 | General register write enable |
| gr_waddr | input | 4 | General register write address |
| gr_wdata | input | 32 | General register write data |

## Verification
The hardest case to reach from the ports is a collision of three things in one edge: a general write to register 15, a status write that flips the stack mode, and the requirement that the old register 15, not the newly written value, lands in the shadow. The bench drives both write ports in the same cycle in both swap directions. It then reads register 15 and both stack pointer addresses, so a dropped or misordered write shows up as a wrong pointer. A reference model keeps the two stack pointers as separate variables and derives register 15 from the mode, so it never copies the swap mechanics.

// File: rtl/sbk_pkg.sv
// Package: shared constants and flag type for the banked stack pointer bank.
// Assumes a 32-bit datapath and a 16-entry general register file.
package sbk_pkg;
    localparam int SP_INDEX      = 15;  // general register holding live SP
    localparam int CA_STATUS     = 0;
    localparam int CA_CONDITION  = 1;
    localparam int CA_INT_SP     = 2;
    localparam int CA_USR_SP     = 3;
    localparam int CA_SCRATCH_LO = 4;
    localparam int N_SCRATCH     = 3;

    // Bit positions within the status word
    localparam int B_BK_MODE = 15;
    localparam int B_BK_IEN  = 14;
    localparam int B_BK_COND = 8;
    localparam int B_MODE    = 7;
    localparam int B_IEN     = 6;
    localparam int B_COND    = 0;

    typedef struct packed {
        logic bk_mode;
        logic bk_ien;
        logic bk_cond;
        logic mode;
        logic ien;
        logic cond;
    } sbk_flags_t;
endpackage

// File: rtl/sbk_gpr_file.sv
// Module: general register file with one extra write port dedicated to the
// stack pointer entry. Assumes the dedicated port has priority over the
// general write port when both target the stack pointer entry.
module sbk_gpr_file #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          sp_we,
    input  logic [DW-1:0] sp_wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] sp_q
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == sbk_pkg::SP_INDEX) begin : g_sp
            // Stack pointer entry: dedicated port overrides the general port
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (sp_we)
                    regs[i] <= sp_wdata;
                else if (we && waddr == AW'(i))
                    regs[i] <= wdata;
            end
        end else begin : g_plain
            // Ordinary entry: written only by the general port
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (we && waddr == AW'(i))
                    regs[i] <= wdata;
            end
        end
    end

    assign rdata = regs[raddr];
    assign sp_q  = regs[sbk_pkg::SP_INDEX];
endmodule

// File: rtl/sbk_flags.sv
// Module: holds the six status flags. A full status write loads all of them
// from their bit positions; a condition write updates the condition only.
// Assumes the two write strobes are never active together.
module sbk_flags #(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               status_we,
    input  logic               cond_we,
    input  logic [DW-1:0]      wdata,
    output sbk_pkg::sbk_flags_t q
);
    import sbk_pkg::*;

    // Flag register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (status_we) begin
            q.bk_mode <= wdata[B_BK_MODE];
            q.bk_ien  <= wdata[B_BK_IEN];
            q.bk_cond <= wdata[B_BK_COND];
            q.mode    <= wdata[B_MODE];
            q.ien     <= wdata[B_IEN];
            q.cond    <= wdata[B_COND];
        end else if (cond_we) begin
            q.cond    <= wdata[B_COND];
        end
    end
endmodule

// File: rtl/sbk_shadow_store.sv
// Module: the two stack pointer shadows plus the plain scratch registers.
// Assumes the parent resolves which shadow is live; this block only stores.
module sbk_shadow_store #(
    parameter int DW   = 32,
    parameter int NSCR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            isp_we,
    input  logic [DW-1:0]   isp_d,
    input  logic            usp_we,
    input  logic [DW-1:0]   usp_d,
    input  logic [NSCR-1:0] scr_we,
    input  logic [DW-1:0]   scr_d,
    output logic [DW-1:0]   isp_q,
    output logic [DW-1:0]   usp_q,
    output logic [DW-1:0]   scr_q [NSCR]
);
    // Interrupt stack pointer shadow
    always_ff @(posedge clk) begin
        if (!rst_n)      isp_q <= '0;
        else if (isp_we) isp_q <= isp_d;
    end

    // User stack pointer shadow
    always_ff @(posedge clk) begin
        if (!rst_n)      usp_q <= '0;
        else if (usp_we) usp_q <= usp_d;
    end

    for (genvar k = 0; k < NSCR; k++) begin : g_scr
        // Scratch register k
        always_ff @(posedge clk) begin
            if (!rst_n)         scr_q[k] <= '0;
            else if (scr_we[k]) scr_q[k] <= scr_d;
        end
    end
endmodule

// File: rtl/sp_bank_ctrl.sv
// Module: top of the banked stack pointer control register bank. Decodes
// control writes, performs the stack pointer swap on a mode change, and
// builds the combinational control read data. Assumes one control write and
// one general write per cycle at most; a swap overrides a general write to
// the stack pointer entry.
module sp_bank_ctrl #(
    parameter int DW    = 32,
    parameter int CR_AW = 3,
    parameter int GR_AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CR_AW-1:0] cr_raddr,
    output logic [DW-1:0]    cr_rdata,
    input  logic             cr_we,
    input  logic [CR_AW-1:0] cr_waddr,
    input  logic [DW-1:0]    cr_wdata,
    input  logic [GR_AW-1:0] gr_raddr,
    output logic [DW-1:0]    gr_rdata,
    input  logic             gr_we,
    input  logic [GR_AW-1:0] gr_waddr,
    input  logic [DW-1:0]    gr_wdata
);
    import sbk_pkg::*;

    localparam int NSCR = N_SCRATCH;

    sbk_flags_t    flags_q;
    logic          stack_mode;
    logic [DW-1:0] sp_q, isp_sh, usp_sh;
    logic [DW-1:0] scr_q [NSCR];
    logic [NSCR-1:0] scr_we;

    logic wr_status, wr_cond, wr_isp, wr_usp, swap;
    logic sp_we, isp_we, usp_we;
    logic [DW-1:0] sp_d, isp_d, usp_d;

    assign stack_mode = flags_q.mode;

    // Control write decode
    always_comb begin
        wr_status = cr_we && (cr_waddr == CR_AW'(CA_STATUS));
        wr_cond   = cr_we && (cr_waddr == CR_AW'(CA_CONDITION));
        wr_isp    = cr_we && (cr_waddr == CR_AW'(CA_INT_SP));
        wr_usp    = cr_we && (cr_waddr == CR_AW'(CA_USR_SP));
        swap      = wr_status && (cr_wdata[B_MODE] != stack_mode);
    end

    // Stack pointer routing: swap or mode-aware pointer writes
    always_comb begin
        sp_we  = swap || (wr_isp && !stack_mode) || (wr_usp && stack_mode);
        sp_d   = swap ? (stack_mode ? isp_sh : usp_sh) : cr_wdata;
        isp_we = (swap && !stack_mode) || (wr_isp && stack_mode);
        isp_d  = swap ? sp_q : cr_wdata;
        usp_we = (swap && stack_mode) || (wr_usp && !stack_mode);
        usp_d  = swap ? sp_q : cr_wdata;
    end

    for (genvar k = 0; k < NSCR; k++) begin : g_scr_dec
        assign scr_we[k] = cr_we && (cr_waddr == CR_AW'(CA_SCRATCH_LO + k));
    end

    sbk_gpr_file #(.DW(DW), .AW(GR_AW)) u_gpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (gr_we),
        .waddr    (gr_waddr),
        .wdata    (gr_wdata),
        .sp_we    (sp_we),
        .sp_wdata (sp_d),
        .raddr    (gr_raddr),
        .rdata    (gr_rdata),
        .sp_q     (sp_q)
    );

    sbk_flags #(.DW(DW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_we (wr_status),
        .cond_we   (wr_cond),
        .wdata     (cr_wdata),
        .q         (flags_q)
    );

    sbk_shadow_store #(.DW(DW), .NSCR(NSCR)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .isp_we (isp_we),
        .isp_d  (isp_d),
        .usp_we (usp_we),
        .usp_d  (usp_d),
        .scr_we (scr_we),
        .scr_d  (cr_wdata),
        .isp_q  (isp_sh),
        .usp_q  (usp_sh),
        .scr_q  (scr_q)
    );

    // Control read multiplexer
    always_comb begin
        cr_rdata = '0;
        if (cr_raddr == CR_AW'(CA_STATUS)) begin
            cr_rdata[B_BK_MODE] = flags_q.bk_mode;
            cr_rdata[B_BK_IEN]  = flags_q.bk_ien;
            cr_rdata[B_BK_COND] = flags_q.bk_cond;
            cr_rdata[B_MODE]    = flags_q.mode;
            cr_rdata[B_IEN]     = flags_q.ien;
            cr_rdata[B_COND]    = flags_q.cond;
        end else if (cr_raddr == CR_AW'(CA_CONDITION)) begin
            cr_rdata[B_COND]    = flags_q.cond;
        end else if (cr_raddr == CR_AW'(CA_INT_SP)) begin
            cr_rdata = stack_mode ? isp_sh : sp_q;
        end else if (cr_raddr == CR_AW'(CA_USR_SP)) begin
            cr_rdata = stack_mode ? sp_q : usp_sh;
        end else begin
            for (int k = 0; k < NSCR; k++)
                if (cr_raddr == CR_AW'(CA_SCRATCH_LO + k))
                    cr_rdata = scr_q[k];
        end
    end
endmodule

// File: rtl/sbk_checker.sv
// Module: assertion checker for sp_bank_ctrl, attached by bind. Observes the
// control write port, the live stack pointer and both shadows over time.
module sbk_checker #(
    parameter int DW    = 32,
    parameter int CR_AW = 3,
    parameter int GR_AW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cr_we,
    input logic [CR_AW-1:0] cr_waddr,
    input logic [DW-1:0]    cr_wdata,
    input logic             gr_we,
    input logic [GR_AW-1:0] gr_waddr,
    input logic [CR_AW-1:0] cr_raddr,
    input logic [DW-1:0]    cr_rdata,
    input logic             mode,
    input logic [DW-1:0]    sp,
    input logic [DW-1:0]    isp,
    input logic [DW-1:0]    usp
);
    logic [DW-1:0] status_mask;
    logic          st_wr, gr_sp_wr;

    always_comb begin
        status_mask = '0;
        status_mask[15] = 1'b1; status_mask[14] = 1'b1; status_mask[8] = 1'b1;
        status_mask[7]  = 1'b1; status_mask[6]  = 1'b1; status_mask[0] = 1'b1;
        st_wr    = cr_we && (cr_waddr == '0);
        gr_sp_wr = gr_we && (gr_waddr == GR_AW'(15));
    end

    a_r1_status_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_raddr == '0) |-> ((cr_rdata & ~status_mask) == '0));

    a_r2_cond_alias_width: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_raddr == CR_AW'(1)) |-> (cr_rdata[DW-1:1] == '0));

    a_r5_swap_to_user: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && cr_wdata[7] && !mode)
        |=> (mode && sp == $past(usp) && isp == $past(sp)));

    a_r6_swap_to_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !cr_wdata[7] && mode)
        |=> (!mode && sp == $past(isp) && usp == $past(sp)));

    a_r7_no_swap_same_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && (cr_wdata[7] == mode) && !gr_sp_wr)
        |=> ($stable(sp) && $stable(isp) && $stable(usp)));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_raddr > CR_AW'(6)) |-> (cr_rdata == '0));

    a_r11_swap_beats_gpr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && (cr_wdata[7] != mode) && gr_sp_wr)
        |=> (sp == ($past(mode) ? $past(isp) : $past(usp))));
endmodule

bind sp_bank_ctrl sbk_checker #(.DW(DW), .CR_AW(CR_AW), .GR_AW(GR_AW)) u_sbk_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cr_we    (cr_we),
    .cr_waddr (cr_waddr),
    .cr_wdata (cr_wdata),
    .gr_we    (gr_we),
    .gr_waddr (gr_waddr),
    .cr_raddr (cr_raddr),
    .cr_rdata (cr_rdata),
    .mode     (stack_mode),
    .sp       (sp_q),
    .isp      (isp_sh),
    .usp      (usp_sh)
);

// File: tb/sp_bank_ctrl_test.sv
// Bench: a stimulus table walked by one loop, then directed reset and
// collision tests. A reference model holds both stack pointers separately.
module sp_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    // Vector: {kind[1:0], addr[3:0], data[31:0]}
    // kind 0 = control write, 1 = general write, 2 = control read, 3 = general read
    localparam int NVEC = 24;
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd1, 4'd15, 32'h1111_0000},   // live ISP via GR15 (R10, R3)
        {2'd0, 4'd3,  32'h2222_0000},   // USP shadow (R4)
        {2'd2, 4'd2,  32'h0},
        {2'd2, 4'd3,  32'h0},
        {2'd0, 4'd0,  32'hFFFF_FFFF},   // mode 0->1 swap, all flags set (R5, R1)
        {2'd2, 4'd0,  32'h0},
        {2'd3, 4'd15, 32'h0},
        {2'd2, 4'd2,  32'h0},
        {2'd0, 4'd2,  32'h3333_0000},   // mode 1: goes to ISP shadow (R3)
        {2'd0, 4'd3,  32'h4444_0000},   // mode 1: goes to GR15 (R4)
        {2'd0, 4'd1,  32'hFFFF_FFFE},   // condition cleared only (R2)
        {2'd2, 4'd1,  32'h0},
        {2'd0, 4'd0,  32'h0000_0180},   // mode stays 1 (R7)
        {2'd3, 4'd15, 32'h0},
        {2'd0, 4'd0,  32'h0000_4001},   // mode 1->0 swap (R6)
        {2'd3, 4'd15, 32'h0},
        {2'd2, 4'd3,  32'h0},
        {2'd0, 4'd4,  32'hA5A5_0004},   // scratch (R8)
        {2'd0, 4'd5,  32'h5A5A_0005},
        {2'd0, 4'd6,  32'hC3C3_0006},
        {2'd0, 4'd7,  32'hDEAD_BEEF},   // ignored (R8)
        {2'd1, 4'd0,  32'h0000_00F0},   // general regs (R10)
        {2'd1, 4'd9,  32'h9999_0009},
        {2'd0, 4'd0,  32'h0000_0040}    // mode stays 0 (R7)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cr_raddr = '0;
    logic [31:0] cr_rdata;
    logic        cr_we = 1'b0;
    logic [2:0]  cr_waddr = '0;
    logic [31:0] cr_wdata = '0;
    logic [3:0]  gr_raddr = '0;
    logic [31:0] gr_rdata;
    logic        gr_we = 1'b0;
    logic [3:0]  gr_waddr = '0;
    logic [31:0] gr_wdata = '0;

    int n_checks = 0;
    int n_errors = 0;

    // Reference model state
    logic [31:0] m_gr [15];
    logic [31:0] m_isp, m_usp;
    logic [31:0] m_scr [3];
    logic m_bkm, m_bki, m_bkc, m_mode, m_ien, m_cond;

    sp_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cr_raddr(cr_raddr), .cr_rdata(cr_rdata),
        .cr_we(cr_we), .cr_waddr(cr_waddr), .cr_wdata(cr_wdata),
        .gr_raddr(gr_raddr), .gr_rdata(gr_rdata),
        .gr_we(gr_we), .gr_waddr(gr_waddr), .gr_wdata(gr_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string cr_req(input int a);
        case (a)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] m_cr_read(input int a);
        logic [31:0] v = '0;
        case (a)
            0: begin
                v[15] = m_bkm; v[14] = m_bki; v[8] = m_bkc;
                v[7] = m_mode; v[6] = m_ien; v[0] = m_cond;
            end
            1: v[0] = m_cond;
            2: v = m_isp;
            3: v = m_usp;
            4, 5, 6: v = m_scr[a-4];
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] m_gr_read(input int i);
        if (i == 15) return m_mode ? m_usp : m_isp;
        return m_gr[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 15; i++) m_gr[i] = '0;
        for (int i = 0; i < 3; i++) m_scr[i] = '0;
        m_isp = '0; m_usp = '0;
        {m_bkm, m_bki, m_bkc, m_mode, m_ien, m_cond} = '0;
    endtask

    // Apply one cycle of writes to the model; a mode-changing status write drops a GR15 write
    task automatic model_apply(input logic cw, input int ca, input logic [31:0] cd,
                               input logic gw, input int ga, input logic [31:0] gd);
        logic flip;
        flip = cw && ca == 0 && (cd[7] != m_mode);
        if (gw) begin
            if (ga == 15) begin
                if (!flip) begin
                    if (m_mode) m_usp = gd; else m_isp = gd;
                end
            end else begin
                m_gr[ga] = gd;
            end
        end
        if (cw) begin
            case (ca)
                0: begin
                    m_bkm = cd[15]; m_bki = cd[14]; m_bkc = cd[8];
                    m_mode = cd[7]; m_ien = cd[6]; m_cond = cd[0];
                end
                1: m_cond = cd[0];
                2: m_isp = cd;
                3: m_usp = cd;
                4, 5, 6: m_scr[ca-4] = cd;
                default: ;
            endcase
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the low phase, commit at the rising edge, return at the next low phase
    task automatic do_write(input logic cw, input int ca, input logic [31:0] cd,
                            input logic gw, input int ga, input logic [31:0] gd);
        cr_we = cw; cr_waddr = 3'(ca); cr_wdata = cd;
        gr_we = gw; gr_waddr = 4'(ga); gr_wdata = gd;
        @(posedge clk);
        @(negedge clk);
        cr_we = 1'b0; gr_we = 1'b0;
        model_apply(cw, ca, cd, gw, ga, gd);
    endtask

    task automatic read_cr(input int a);
        cr_raddr = 3'(a);
        #1;
        check(cr_req(a), $sformatf("ctrl addr %0d", a), cr_rdata, m_cr_read(a));
    endtask

    task automatic read_gr(input int i);
        gr_raddr = 4'(i);
        #1;
        check("R10", $sformatf("gen reg %0d", i), gr_rdata, m_gr_read(i));
    endtask

    task automatic sweep();
        for (int a = 0; a < 8; a++) read_cr(a);
        for (int i = 0; i < 16; i++) read_gr(i);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        apply_reset();
        sweep();  // R9: everything zero after reset

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  kind;
            logic [3:0]  addr;
            logic [31:0] data;
            {kind, addr, data} = VEC[v];
            case (kind)
                2'd0: begin
                    do_write(1'b1, int'(addr), data, 1'b0, 0, '0);
                    read_cr(2); read_cr(3); read_gr(15);
                end
                2'd1: do_write(1'b0, 0, '0, 1'b1, int'(addr), data);
                2'd2: read_cr(int'(addr));
                default: read_gr(int'(addr));
            endcase
        end
        sweep();

        // R11: GR15 write collides with a 0->1 swap; swap wins, old GR15 moves to ISP
        do_write(1'b0, 0, '0, 1'b1, 15, 32'h0BAD_0015);
        do_write(1'b1, 2, 32'h1234_5678, 1'b0, 0, '0);   // mode 0: ISP lives in GR15
        do_write(1'b1, 3, 32'h8765_4321, 1'b0, 0, '0);   // USP shadow
        do_write(1'b1, 0, 32'h0000_0080, 1'b1, 15, 32'hFFFF_0000);
        gr_raddr = 4'd15; #1;
        check("R11", "GR15 after collision 0->1", gr_rdata, 32'h8765_4321);
        cr_raddr = 3'd2; #1;
        check("R11", "ISP after collision 0->1", cr_rdata, 32'h1234_5678);

        // R11: collision in the 1->0 direction
        do_write(1'b1, 0, 32'h0000_0000, 1'b1, 15, 32'hEEEE_0000);
        gr_raddr = 4'd15; #1;
        check("R11", "GR15 after collision 1->0", gr_rdata, 32'h1234_5678);
        cr_raddr = 3'd3; #1;
        check("R11", "USP after collision 1->0", cr_rdata, 32'h8765_4321);

        // R7: GR15 write with a same-mode status write is kept
        do_write(1'b1, 0, 32'h0000_0001, 1'b1, 15, 32'h7777_0000);
        gr_raddr = 4'd15; #1;
        check("R7", "GR15 kept when mode unchanged", gr_rdata, 32'h7777_0000);
        sweep();

        // R9: reset in the middle of activity clears state
        do_write(1'b1, 0, 32'h0000_C1C1, 1'b1, 4, 32'h4444_4444);
        do_write(1'b1, 5, 32'h5555_5555, 1'b0, 0, '0);
        apply_reset();
        sweep();
        cr_raddr = 3'd0; #1;
        check("R9", "status cleared by reset", cr_rdata, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule